// File: doc/BRIEF.md
# Byte-Reversed Indexed Load/Store Unit

This execution unit handles the byte-reversed indexed memory instructions of a 64-bit big-endian processor. It takes one instruction word at a time and reads two address operands plus a store-data operand from the register file. It forms the effective address by adding the two address operands. When the base field is zero, a literal zero is used as the base. The unit then moves the data one byte at a time over a byte-wide request/response memory port. Bytes go to ascending addresses, so there is no alignment constraint.

On loads, the byte at the lowest address becomes the least significant byte of the result. The result is written to the destination register. Halfword and word results are zero-extended and are never sign-extended. Stores do the inverse: the least significant byte of the source register goes to the lowest address. The unit never writes the base register back and holds no condition or status state. Any opcode outside the supported set raises a one-cycle illegal flag and causes no memory or register activity.

Top module: `brx_lsu`

## Requirements
- R1: Bits use big-endian numbering, where bit 0 is the MSB of the 32-bit word. Bits 0-5 are the primary opcode and must equal 31. Bits 6-10 are the target/source register, bits 11-15 the base register, bits 16-20 the index register, and bits 21-30 the extended opcode. Bit 31 is the record flag and is ignored. The accepted extended opcodes are: 532 (8-byte load), 534 (4-byte load), 790 (2-byte load), 660 (8-byte store), 662 (4-byte store) and 918 (2-byte store). The 8-byte load with all register fields zero encodes as 0x7c000428.
- R2: The effective address is the index register value plus the base register value, modulo 2^64. When the base field is 0, the base is the constant zero and register 0 is not used.
- R3: A load of N bytes places the byte read from EA+i into result bits [8i+7:8i]. Bits above 8N are zero. The full 64-bit result is written to the register named in bits 6-10.
- R4: A store of N bytes sends source-register bits [8i+7:8i] to address EA+i.
- R5: An access of N bytes issues exactly N single-byte requests. Their addresses are EA, EA+1, ... EA+N-1 in that order, with wraparound at 2^64 and no alignment requirement.
- R6: A pending request keeps its valid, address, write flag and write data unchanged until a response is returned.
- R7: done is high for exactly one cycle, the cycle after the last byte's response. On loads the single register write happens in that same cycle. Stores write no register, and the base register is never written.
- R8: Any other primary or extended opcode raises illegal for one cycle, starting the cycle after acceptance. It makes no memory request, does no register write and does not pulse done.
- R9: insn_ready is low from acceptance of a legal instruction until after done. An instruction presented while insn_ready is low is ignored.
- R10: After reset, insn_ready is high and mem_req_valid, done, illegal and rf_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| insn_ready | output | 1 | Unit idle, instruction accepted when valid |
| rf_a_idx | output | 5 | Base register read index |
| rf_a_data | input | 64 | Base register value |
| rf_b_idx | output | 5 | Index register read index |
| rf_b_data | input | 64 | Index register value |
| rf_s_idx | output | 5 | Store source register read index |
| rf_s_data | input | 64 | Store source register value |
| rf_we | output | 1 | Register write enable |
| rf_wr_idx | output | 5 | Register write index |
| rf_wr_data | output | 64 | Register write data |
| mem_req_valid | output | 1 | Byte request pending |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Request completed this cycle |
| mem_rsp_rdata | input | 8 | Byte read |
| done | output | 1 | Instruction finished |
| illegal | output | 1 | Unsupported instruction |

## Verification
The assertions check the following on every cycle:
- a pending request holds steady until its response;
- consecutive byte addresses step by one;
- done and illegal are single-cycle pulses;
- a register write only ever appears alongside done;
- the illegal flag never coincides with memory or register activity;
- no request is issued while the unit reports itself ready.

Some behaviours can only be shown by the bench scenarios, which compare against a reference memory and register model:
- the byte placement of the reversed data for each of the three sizes;
- zero-extension of narrow loads;
- substitution of zero for a base field of 0;
- address wraparound;
- the exact set of accepted opcodes;
- that instructions offered while busy are ignored.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned RIDX_W = 5;
  localparam logic [5:0] PRIMARY_X = 6'd31;

  localparam logic [9:0] XO_LD8 = 10'd532;
  localparam logic [9:0] XO_LD4 = 10'd534;
  localparam logic [9:0] XO_LD2 = 10'd790;
  localparam logic [9:0] XO_ST8 = 10'd660;
  localparam logic [9:0] XO_ST4 = 10'd662;
  localparam logic [9:0] XO_ST2 = 10'd918;

  // lg_bytes: log2 of the transfer size in bytes (1, 2 or 3)
  typedef struct packed {
    logic       legal;
    logic       store;
    logic [1:0] lg_bytes;
  } brx_op_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_FIN  = 2'd2
  } brx_state_e;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output brx_op_t           op,
  output logic [RIDX_W-1:0] rt_idx,
  output logic [RIDX_W-1:0] ra_idx,
  output logic [RIDX_W-1:0] rb_idx
);
  logic [5:0] primary;
  logic [9:0] xo;

  // big-endian bit k of the word is insn[31-k]
  assign primary = insn[31:26];
  assign rt_idx  = insn[25:21];
  assign ra_idx  = insn[20:16];
  assign rb_idx  = insn[15:11];
  assign xo      = insn[10:1];

  always_comb begin
    op = '0;
    if (primary == PRIMARY_X) begin
      unique case (xo)
        XO_LD8:  op = '{legal: 1'b1, store: 1'b0, lg_bytes: 2'd3};
        XO_LD4:  op = '{legal: 1'b1, store: 1'b0, lg_bytes: 2'd2};
        XO_LD2:  op = '{legal: 1'b1, store: 1'b0, lg_bytes: 2'd1};
        XO_ST8:  op = '{legal: 1'b1, store: 1'b1, lg_bytes: 2'd3};
        XO_ST4:  op = '{legal: 1'b1, store: 1'b1, lg_bytes: 2'd2};
        XO_ST2:  op = '{legal: 1'b1, store: 1'b1, lg_bytes: 2'd1};
        default: op = '0;
      endcase
    end
  end

  // R1: a legal decode always names a nonzero transfer size
  always_comb begin
    if (op.legal) begin
      p_size_nonzero_r1: assert (op.lg_bytes != 2'd0);
    end
  end
endmodule

// File: rtl/brx_agu.sv
module brx_agu #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned RIDX_W = 5
) (
  input  logic [RIDX_W-1:0] ra_idx,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   b_val,
  output logic [XLEN-1:0]   ea
);
  logic [XLEN-1:0] base;

  // base field 0 selects the constant zero, not register 0
  assign base = (ra_idx == '0) ? '0 : a_val;
  assign ea   = b_val + base;
endmodule

// File: rtl/brx_seq.sv
module brx_seq
  import brx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  brx_op_t           op,
  input  logic [RIDX_W-1:0] rt,
  input  logic [XLEN-1:0]   ea,
  input  logic [XLEN-1:0]   sdata,
  output logic              ready,
  output logic              req_valid,
  output logic              req_we,
  output logic [XLEN-1:0]   req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_rdata,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic              done,
  output logic              illegal
);
  localparam int unsigned BYTES = XLEN / 8;
  localparam int unsigned CNT_W = $clog2(BYTES);

  brx_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, last_q, last_d;
  logic [XLEN-1:0]   ea_q, ea_d, data_q, data_d;
  logic              store_q, store_d, ill_q, ill_d;
  logic [RIDX_W-1:0] rt_q, rt_d;
  logic              cap_en, step_en;
  logic              hs;

  assign hs = (st_q == S_XFER) && rsp_valid;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    ea_d    = ea_q;
    data_d  = data_q;
    store_d = store_q;
    rt_d    = rt_q;
    ill_d   = 1'b0;
    cap_en  = 1'b0;
    step_en = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          if (op.legal) begin
            cap_en  = 1'b1;
            st_d    = S_XFER;
            cnt_d   = '0;
            last_d  = CNT_W'((1 << op.lg_bytes) - 1);
            ea_d    = ea;
            store_d = op.store;
            rt_d    = rt;
            data_d  = op.store ? sdata : '0;
          end else begin
            ill_d = 1'b1;
          end
        end
      end
      S_XFER: begin
        if (hs) begin
          step_en = 1'b1;
          if (!store_q) data_d[{cnt_q, 3'b000} +: 8] = rsp_rdata;
          if (cnt_q == last_q) st_d = S_FIN;
          else                 cnt_d = cnt_q + 1'b1;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      ill_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ill_q <= ill_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      last_q  <= '0;
      ea_q    <= '0;
      store_q <= 1'b0;
      rt_q    <= '0;
      data_q  <= '0;
    end else begin
      if (cap_en) begin
        last_q  <= last_d;
        ea_q    <= ea_d;
        store_q <= store_d;
        rt_q    <= rt_d;
      end
      if (cap_en || step_en) begin
        cnt_q  <= cnt_d;
        data_q <= data_d;
      end
    end
  end

  assign ready     = (st_q == S_IDLE);
  assign req_valid = (st_q == S_XFER);
  assign req_we    = store_q;
  assign req_addr  = ea_q + XLEN'(cnt_q);
  assign req_wdata = data_q[{cnt_q, 3'b000} +: 8];
  assign done      = (st_q == S_FIN);
  assign wr_en     = (st_q == S_FIN) && !store_q;
  assign wr_idx    = rt_q;
  assign wr_data   = data_q;
  assign illegal   = ill_q;

  // R6: a pending request holds steady until answered
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !rsp_valid |=> req_valid && $stable(req_addr) &&
                                $stable(req_we) && $stable(req_wdata));

  // R5: successive requests within one access step by one byte
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && rsp_valid && !$past(1'b0) && (cnt_q != last_q)
      |=> req_valid && (req_addr == $past(req_addr) + 1'b1));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: register writes only appear with done
  p_wr_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> done);

  // R8: illegal never overlaps memory or register activity
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !req_valid && !wr_en && !done);

  // R8: illegal is a single-cycle pulse
  p_illegal_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && !$past(start) |-> 1'b0 || !illegal);

  // R9: no request while reporting idle
  p_busy_when_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !ready);

  // R7: the last response leads to done on the next cycle
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hs && (cnt_q == last_q) |=> done);
endmodule

// File: rtl/brx_lsu.sv
module brx_lsu
  import brx_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  input  logic [31:0]       insn,
  output logic              insn_ready,
  output logic [4:0]        rf_a_idx,
  input  logic [XLEN-1:0]   rf_a_data,
  output logic [4:0]        rf_b_idx,
  input  logic [XLEN-1:0]   rf_b_data,
  output logic [4:0]        rf_s_idx,
  input  logic [XLEN-1:0]   rf_s_data,
  output logic              rf_we,
  output logic [4:0]        rf_wr_idx,
  output logic [XLEN-1:0]   rf_wr_data,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [XLEN-1:0]   mem_req_addr,
  output logic [7:0]        mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [7:0]        mem_rsp_rdata,
  output logic              done,
  output logic              illegal
);
  brx_op_t           op;
  logic [RIDX_W-1:0] rt_idx, ra_idx, rb_idx;
  logic [XLEN-1:0]   ea;
  logic              start;

  brx_decode u_dec (
    .insn   (insn),
    .op     (op),
    .rt_idx (rt_idx),
    .ra_idx (ra_idx),
    .rb_idx (rb_idx)
  );

  assign rf_a_idx = ra_idx;
  assign rf_b_idx = rb_idx;
  assign rf_s_idx = rt_idx;

  brx_agu #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_agu (
    .ra_idx (ra_idx),
    .a_val  (rf_a_data),
    .b_val  (rf_b_data),
    .ea     (ea)
  );

  assign start = insn_valid && insn_ready;

  brx_seq #(.XLEN(XLEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .rt        (rt_idx),
    .ea        (ea),
    .sdata     (rf_s_data),
    .ready     (insn_ready),
    .req_valid (mem_req_valid),
    .req_we    (mem_req_we),
    .req_addr  (mem_req_addr),
    .req_wdata (mem_req_wdata),
    .rsp_valid (mem_rsp_valid),
    .rsp_rdata (mem_rsp_rdata),
    .wr_en     (rf_we),
    .wr_idx    (rf_wr_idx),
    .wr_data   (rf_wr_data),
    .done      (done),
    .illegal   (illegal)
  );

  // R2: first byte of a legal access goes to the computed address
  p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && op.legal |=> mem_req_valid && (mem_req_addr == $past(ea)));

  // R8: an unsupported word yields illegal and no request
  p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !op.legal |=> illegal && !mem_req_valid);
endmodule

// File: tb/sim_brx_lsu.sv
`timescale 1ns/1ps
module sim_brx_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        insn_ready;
  logic [4:0]  rf_a_idx, rf_b_idx, rf_s_idx, rf_wr_idx;
  logic [63:0] rf_a_data, rf_b_data, rf_s_data, rf_wr_data;
  logic        rf_we;
  logic        mem_req_valid, mem_req_we;
  logic [63:0] mem_req_addr;
  logic [7:0]  mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_rdata = '0;
  logic        done, illegal;

  logic [63:0] regs [32];
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign rf_a_data = regs[rf_a_idx];
  assign rf_b_data = regs[rf_b_idx];
  assign rf_s_data = regs[rf_s_idx];

  brx_lsu u0 (.*);

  function automatic logic [7:0] memfn(input logic [63:0] a);
    return (a[7:0] * 8'd37) ^ a[23:16] ^ a[63:56] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] p, input logic [9:0] xo,
                                     input logic [4:0] t, input logic [4:0] a,
                                     input logic [4:0] b);
    return {p, t, a, b, xo, 1'b0};
  endfunction

  // expected decode: returns byte count, 0 for unsupported
  function automatic int exp_bytes(input logic [31:0] w, output bit st);
    st = 1'b0;
    if (w[31:26] != 6'd31) return 0;
    case (w[10:1])
      10'd532: return 8;
      10'd534: return 4;
      10'd790: return 2;
      10'd660: begin st = 1'b1; return 8; end
      10'd662: begin st = 1'b1; return 4; end
      10'd918: begin st = 1'b1; return 2; end
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input bit noise);
    bit          st;
    int          n;
    logic [4:0]  rt, ra, rb;
    logic [63:0] ea, sval, expv;
    logic [63:0] la [16];
    logic        lwe [16];
    logic [7:0]  lwd [16];
    int          nlog, wr_cnt, cyc, wt;
    bit          seen_done, seen_ill, pend;
    logic [63:0] pend_addr, wr_dat;
    logic [4:0]  wr_i;
    n    = exp_bytes(w, st);
    rt   = w[25:21];
    ra   = w[20:16];
    rb   = w[15:11];
    ea   = regs[rb] + ((ra == 5'd0) ? 64'd0 : regs[ra]);
    sval = regs[rt];
    while (!insn_ready) @(negedge clk);
    insn_valid = 1'b1;
    insn = w;
    @(negedge clk);
    insn_valid = 1'b0;
    nlog = 0; wr_cnt = 0; cyc = 0; wt = 0;
    seen_done = 0; seen_ill = 0; pend = 0;
    pend_addr = '0; wr_dat = '0; wr_i = '0;
    if (n != 0) chk(insn_ready == 1'b0, "R9", "ready after accept", {63'd0, insn_ready}, 64'd0);
    while (!(seen_done || seen_ill) && cyc < 200) begin
      if (noise && cyc == 1) begin
        insn_valid = 1'b1;
        insn = mk(6'd31, 10'd533, 5'd1, 5'd2, 5'd3);
      end else begin
        insn_valid = 1'b0;
      end
      if (done) seen_done = 1;
      if (illegal) seen_ill = 1;
      if (rf_we) begin
        wr_cnt++;
        wr_i = rf_wr_idx;
        wr_dat = rf_wr_data;
      end
      if (pend)
        chk(mem_req_valid && mem_req_addr == pend_addr, "R6", "held request",
            mem_req_addr, pend_addr);
      if (mem_rsp_valid) begin
        mem_rsp_valid = 1'b0;
        pend = 0;
      end else if (mem_req_valid) begin
        if (wt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_rdata = memfn(mem_req_addr);
          if (nlog < 16) begin
            la[nlog] = mem_req_addr;
            lwe[nlog] = mem_req_we;
            lwd[nlog] = mem_req_wdata;
          end
          nlog++;
          pend = 0;
          wt = $urandom % 3;
        end else begin
          wt--;
          pend = 1;
          pend_addr = mem_req_addr;
        end
      end
      @(negedge clk);
      cyc++;
    end
    insn_valid = 1'b0;
    mem_rsp_valid = 1'b0;
    chk(cyc < 200, "R7", "completion", cyc, 200);
    chk(!done && !illegal && !rf_we, "R7", "pulse ends", {61'd0, done, illegal, rf_we}, 64'd0);
    if (n == 0) begin
      chk(seen_ill, "R8", "illegal raised", seen_ill, 1);
      chk(nlog == 0, "R8", "no memory access", nlog, 0);
      chk(wr_cnt == 0 && !seen_done, "R8", "no write or done", wr_cnt, 0);
    end else begin
      chk(!seen_ill, noise ? "R9" : "R1", "no illegal", seen_ill, 0);
      chk(seen_done, "R7", "done seen", seen_done, 1);
      chk(nlog == n, "R5", "byte count", nlog, n);
      for (int i = 0; i < n && i < nlog; i++) begin
        chk(la[i] == ea + 64'(i), (i == 0) ? "R2" : "R5", "byte address", la[i], ea + 64'(i));
        chk(lwe[i] == st, "R1", "direction", lwe[i], st);
        if (st) chk(lwd[i] == sval[8*i +: 8], "R4", "store byte", lwd[i], sval[8*i +: 8]);
      end
      if (st) begin
        chk(wr_cnt == 0, "R7", "store writes no register", wr_cnt, 0);
      end else begin
        expv = '0;
        for (int i = 0; i < n; i++) expv[8*i +: 8] = memfn(ea + 64'(i));
        chk(wr_cnt == 1, "R7", "single register write", wr_cnt, 1);
        chk(wr_i == rt, "R3", "write index", wr_i, rt);
        chk(wr_dat == expv, "R3", "load value", wr_dat, expv);
        regs[rt] = expv;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [9:0] xos [6];
    xos[0] = 10'd532; xos[1] = 10'd534; xos[2] = 10'd790;
    xos[3] = 10'd660; xos[4] = 10'd662; xos[5] = 10'd918;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) regs[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(insn_ready && !mem_req_valid && !done && !illegal && !rf_we, "R10", "reset state",
        {59'd0, insn_ready, mem_req_valid, done, illegal, rf_we}, 64'h10);

    // R1: 0x7c000428 is the 8-byte load; base 0 means zero, index r0
    regs[0] = 64'h0000_0000_0000_1235;
    run(32'h7c000428, 0);
    // R2: base field 0 ignores register 0 contents
    regs[0] = 64'h1000_0000_0000_0000;
    regs[7] = 64'h40;
    run(mk(6'd31, 10'd532, 5'd9, 5'd0, 5'd7), 0);
    // R5: unaligned access wrapping past the top of the address space
    regs[3] = 64'hFFFF_FFFF_FFFF_FFFD;
    regs[4] = 64'd0;
    run(mk(6'd31, 10'd532, 5'd10, 5'd3, 5'd4), 0);
    run(mk(6'd31, 10'd660, 5'd11, 5'd3, 5'd4), 0);
    // R3: narrow loads zero-extend even with top bit set in the data
    regs[12] = 64'hFFFF_FFFF_FFFF_FFFF;
    run(mk(6'd31, 10'd790, 5'd12, 5'd5, 5'd6), 0);
    regs[12] = 64'hFFFF_FFFF_FFFF_FFFF;
    run(mk(6'd31, 10'd534, 5'd12, 5'd6, 5'd5), 0);
    // R8: unknown extended and primary opcodes
    run(mk(6'd31, 10'd533, 5'd1, 5'd2, 5'd3), 0);
    run(mk(6'd30, 10'd532, 5'd1, 5'd2, 5'd3), 0);
    // R9: instruction offered while busy is ignored
    run(mk(6'd31, 10'd918, 5'd13, 5'd2, 5'd3), 1);
    run(mk(6'd31, 10'd532, 5'd14, 5'd2, 5'd3), 1);

    for (int k = 0; k < 60; k++) begin
      logic [9:0] xo;
      logic [5:0] p;
      p  = 6'd31;
      xo = xos[$urandom % 6];
      if ($urandom % 8 == 0) xo = 10'($urandom);
      if ($urandom % 16 == 0) p = 6'($urandom);
      for (int r = 1; r < 32; r++) if ($urandom % 4 == 0) regs[r] = {$urandom, $urandom};
      run(mk(p, xo, 5'($urandom), 5'($urandom), 5'($urandom)), ($urandom % 5) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule